// File: doc/BRIEF.md
# Two-Bank Address Sorter with Holding Slot

This block sits in front of a cache split into two interleaved banks, one for even doublewords and one for odd doublewords. Each cycle it can take up to two memory references from the issuing pipeline. It sends each reference through a small crossbar to the bank picked by the doubleword address bit. Each bank port carries at most one reference per cycle.

When both new references want the same bank, the older one (port 0) goes out at once. The other waits in a one-entry holding slot and goes out in the next cycle, where it can pair with a new reference for the opposite bank. A stream of same-bank pairs that alternates between the banks therefore keeps both banks busy every cycle after the first, instead of running at half rate.

If the holding slot is occupied and two of the new references cannot be placed, the block raises `stall`. The pipeline must then present the same references again. A `flush` input drops everything in flight.

Top module: `asort_top`

## Requirements
- R1: The bank is chosen by address bit `BANK_BIT` (default 3, the doubleword bit of a byte address). A value of 0 goes to the even port and 1 goes to the odd port. The address and tag pass through unchanged.
- R2: With the holding slot empty, two valid references to different banks both issue in the same cycle and `stall` stays low.
- R3: With the holding slot empty, two valid references to the same bank cause port 0 to issue in that cycle. Port 1 is taken into the holding slot.
- R4: A held reference issues on its bank in the cycle after it was captured. It comes ahead of any new reference to that bank.
- R5: When a reference is held, a new reference for the other bank issues in the same cycle. A single new reference for the held bank moves into the slot without a stall.
- R6: `stall` is high when the slot is occupied and both new references need its bank. In that case neither input is accepted, the held reference still issues, and `stall` is never high in two consecutive cycles.
- R7: While `flush` is high, no bank output is valid, `stall` is low and the inputs are dropped. The slot is empty in the next cycle.
- R8: During and right after reset, both bank outputs are invalid, `stall` is low and the slot is empty.
- R9: Alternating pairs (two even, then two odd, and so on) produce valid outputs on both banks in every cycle after the first, with no stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Drop inputs and clear the holding slot |
| in0_vld | input | 1 | Port 0 (older) reference valid |
| in0_addr | input | AW | Port 0 byte address |
| in0_tag | input | TW | Port 0 reference tag |
| in1_vld | input | 1 | Port 1 (younger) reference valid |
| in1_addr | input | AW | Port 1 byte address |
| in1_tag | input | TW | Port 1 reference tag |
| even_vld | output | 1 | Even bank reference valid |
| even_addr | output | AW | Even bank address |
| even_tag | output | TW | Even bank tag |
| odd_vld | output | 1 | Odd bank reference valid |
| odd_addr | output | AW | Odd bank address |
| odd_tag | output | TW | Odd bank tag |
| stall | output | 1 | Inputs not accepted this cycle; present them again |

## Verification
A wrong slot state shows up at the ports one cycle after the pair that should have filled it. A lost entry shows as a missing reference on a bank. A stale entry shows as a duplicate or out-of-order reference, or as a `stall` where none is due. A wrong priority between the held entry and port 0 shows in the same cycle as the wrong reference on a bank port. The bench compares both bank ports and `stall` against its own model every cycle. This catches any such fault within one cycle of its effect.

// File: rtl/asort_pkg.sv
package asort_pkg;
  typedef enum logic {
    BANK_EVEN = 1'b0,
    BANK_ODD  = 1'b1
  } bank_e;

  localparam int NSRC     = 3;
  localparam int SRC_HELD = 0;
  localparam int SRC_P0   = 1;
  localparam int SRC_P1   = 2;
endpackage

// File: rtl/asort_alloc.sv
module asort_alloc
  import asort_pkg::*;
(
  input  logic            flush,
  input  logic [NSRC-1:0] src_vld,
  input  logic [NSRC-1:0] src_bank,
  output logic [NSRC-1:0] grant_even,
  output logic [NSRC-1:0] grant_odd,
  output logic            stall,
  output logic            hold_load,
  output logic            hold_sel
);
  logic held_even, held_odd;
  logic free0, iss0, pend0;
  logic taken1, iss1, pend1;
  logic accept;

  always_comb begin
    held_even = src_vld[SRC_HELD] & (src_bank[SRC_HELD] == BANK_EVEN);
    held_odd  = src_vld[SRC_HELD] & (src_bank[SRC_HELD] == BANK_ODD);

    free0 = (src_bank[SRC_P0] == BANK_ODD) ? ~held_odd : ~held_even;
    iss0  = src_vld[SRC_P0] & free0;
    pend0 = src_vld[SRC_P0] & ~free0;

    taken1 = (src_bank[SRC_P1] == BANK_ODD)
           ? (held_odd  | (iss0 & (src_bank[SRC_P0] == BANK_ODD)))
           : (held_even | (iss0 & (src_bank[SRC_P0] == BANK_EVEN)));
    iss1  = src_vld[SRC_P1] & ~taken1;
    pend1 = src_vld[SRC_P1] & taken1;

    stall  = ~flush & pend0 & pend1;
    accept = ~flush & ~stall;

    grant_even = '0;
    grant_odd  = '0;
    grant_even[SRC_HELD] = ~flush & held_even;
    grant_odd[SRC_HELD]  = ~flush & held_odd;
    grant_even[SRC_P0]   = accept & iss0 & (src_bank[SRC_P0] == BANK_EVEN);
    grant_odd[SRC_P0]    = accept & iss0 & (src_bank[SRC_P0] == BANK_ODD);
    grant_even[SRC_P1]   = accept & iss1 & (src_bank[SRC_P1] == BANK_EVEN);
    grant_odd[SRC_P1]    = accept & iss1 & (src_bank[SRC_P1] == BANK_ODD);

    hold_load = accept & (pend0 | pend1);
    hold_sel  = pend1;
  end
endmodule

// File: rtl/asort_hold.sv
module asort_hold #(
  parameter int RW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [RW-1:0] din,
  output logic          q_vld,
  output logic [RW-1:0] q_ref
);
  logic          vld_d;
  logic [RW-1:0] ref_d;

  always_comb begin
    vld_d = load;
    ref_d = load ? din : q_ref;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_vld <= 1'b0;
    else        q_vld <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (load) q_ref <= ref_d;
  end
endmodule

// File: rtl/asort_xbar.sv
module asort_xbar
  import asort_pkg::*;
#(
  parameter int RW = 24
) (
  input  logic [NSRC-1:0][RW-1:0] src_ref,
  input  logic [1:0][NSRC-1:0]    grant,
  output logic [1:0]              bank_vld,
  output logic [1:0][RW-1:0]      bank_ref
);
  for (genvar b = 0; b < 2; b++) begin : g_bank
    always_comb begin
      bank_vld[b] = |grant[b];
      bank_ref[b] = '0;
      for (int s = 0; s < NSRC; s++)
        bank_ref[b] = bank_ref[b] | (src_ref[s] & {RW{grant[b][s]}});
    end
  end
endmodule

// File: rtl/asort_top.sv
module asort_top
  import asort_pkg::*;
#(
  parameter int AW       = 16,
  parameter int TW       = 8,
  parameter int BANK_BIT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          in0_vld,
  input  logic [AW-1:0] in0_addr,
  input  logic [TW-1:0] in0_tag,
  input  logic          in1_vld,
  input  logic [AW-1:0] in1_addr,
  input  logic [TW-1:0] in1_tag,
  output logic          even_vld,
  output logic [AW-1:0] even_addr,
  output logic [TW-1:0] even_tag,
  output logic          odd_vld,
  output logic [AW-1:0] odd_addr,
  output logic [TW-1:0] odd_tag,
  output logic          stall
);
  localparam int RW = AW + TW;

  logic          hold_vld;
  logic [RW-1:0] hold_ref;
  logic [AW-1:0] hold_addr;
  logic [TW-1:0] hold_tag;
  logic          hold_load, hold_sel;
  logic [RW-1:0] hold_din;

  logic [NSRC-1:0]          src_vld, src_bank;
  logic [NSRC-1:0][RW-1:0]  src_ref;
  logic [1:0][NSRC-1:0]     grant;
  logic [1:0]               bank_vld;
  logic [1:0][RW-1:0]       bank_ref;

  assign hold_addr = hold_ref[RW-1:TW];
  assign hold_tag  = hold_ref[TW-1:0];

  assign src_vld[SRC_HELD] = hold_vld;
  assign src_vld[SRC_P0]   = in0_vld;
  assign src_vld[SRC_P1]   = in1_vld;
  assign src_ref[SRC_HELD] = hold_ref;
  assign src_ref[SRC_P0]   = {in0_addr, in0_tag};
  assign src_ref[SRC_P1]   = {in1_addr, in1_tag};

  for (genvar s = 0; s < NSRC; s++) begin : g_bank_sel
    assign src_bank[s] = src_ref[s][TW + BANK_BIT];
  end

  asort_alloc alloc_i (
    .flush      (flush),
    .src_vld    (src_vld),
    .src_bank   (src_bank),
    .grant_even (grant[BANK_EVEN]),
    .grant_odd  (grant[BANK_ODD]),
    .stall      (stall),
    .hold_load  (hold_load),
    .hold_sel   (hold_sel)
  );

  assign hold_din = hold_sel ? src_ref[SRC_P1] : src_ref[SRC_P0];

  asort_hold #(.RW(RW)) hold_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (hold_load),
    .din   (hold_din),
    .q_vld (hold_vld),
    .q_ref (hold_ref)
  );

  asort_xbar #(.RW(RW)) xbar_i (
    .src_ref  (src_ref),
    .grant    (grant),
    .bank_vld (bank_vld),
    .bank_ref (bank_ref)
  );

  assign even_vld  = bank_vld[BANK_EVEN];
  assign even_addr = bank_ref[BANK_EVEN][RW-1:TW];
  assign even_tag  = bank_ref[BANK_EVEN][TW-1:0];
  assign odd_vld   = bank_vld[BANK_ODD];
  assign odd_addr  = bank_ref[BANK_ODD][RW-1:TW];
  assign odd_tag   = bank_ref[BANK_ODD][TW-1:0];
endmodule

// File: rtl/asort_chk.sv
module asort_chk #(
  parameter int AW       = 16,
  parameter int TW       = 8,
  parameter int BANK_BIT = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          in0_vld,
  input logic          in0_bank,
  input logic          in1_vld,
  input logic [AW-1:0] in1_addr,
  input logic [TW-1:0] in1_tag,
  input logic          even_vld,
  input logic [AW-1:0] even_addr,
  input logic [TW-1:0] even_tag,
  input logic          odd_vld,
  input logic [AW-1:0] odd_addr,
  input logic [TW-1:0] odd_tag,
  input logic          stall,
  input logic          hold_vld,
  input logic [AW-1:0] hold_addr,
  input logic [TW-1:0] hold_tag
);
  AST_EVEN_BANK_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    even_vld |-> (even_addr[BANK_BIT] == 1'b0)); // R1
  AST_ODD_BANK_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    odd_vld |-> (odd_addr[BANK_BIT] == 1'b1)); // R1
  AST_SPLIT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_vld && !flush && in0_vld && in1_vld && (in0_bank != in1_addr[BANK_BIT]))
    |-> (even_vld && odd_vld && !stall)); // R2
  AST_SAME_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_vld && !flush && in0_vld && in1_vld && (in0_bank == in1_addr[BANK_BIT]))
    |=> (hold_vld && hold_addr == $past(in1_addr) && hold_tag == $past(in1_tag))); // R3
  AST_HELD_EVEN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_vld && !flush && !hold_addr[BANK_BIT])
    |-> (even_vld && even_addr == hold_addr && even_tag == hold_tag)); // R4
  AST_HELD_ODD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_vld && !flush && hold_addr[BANK_BIT])
    |-> (odd_vld && odd_addr == hold_addr && odd_tag == hold_tag)); // R4
  AST_STALL_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> hold_vld); // R6
  AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall); // R6
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!even_vld && !odd_vld && !stall)); // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !hold_vld); // R7
endmodule

bind asort_top asort_chk #(.AW(AW), .TW(TW), .BANK_BIT(BANK_BIT)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .in0_vld   (in0_vld),
  .in0_bank  (src_bank[asort_pkg::SRC_P0]),
  .in1_vld   (in1_vld),
  .in1_addr  (in1_addr),
  .in1_tag   (in1_tag),
  .even_vld  (even_vld),
  .even_addr (even_addr),
  .even_tag  (even_tag),
  .odd_vld   (odd_vld),
  .odd_addr  (odd_addr),
  .odd_tag   (odd_tag),
  .stall     (stall),
  .hold_vld  (hold_vld),
  .hold_addr (hold_addr),
  .hold_tag  (hold_tag)
);

// File: tb/asort_top_tb_top.sv
`timescale 1ns/1ps
module asort_top_tb_top;
  localparam int AW = 16;
  localparam int TW = 8;
  localparam int BB = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic in0_vld = 1'b0, in1_vld = 1'b0;
  logic [AW-1:0] in0_addr = '0, in1_addr = '0;
  logic [TW-1:0] in0_tag = '0, in1_tag = '0;
  logic even_vld, odd_vld, stall;
  logic [AW-1:0] even_addr, odd_addr;
  logic [TW-1:0] even_tag, odd_tag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state
  logic          m_hv = 1'b0;
  logic [AW-1:0] m_ha = '0;
  logic [TW-1:0] m_ht = '0;
  logic          m_stall_prev = 1'b0;

  always #2 clk = ~clk;

  asort_top #(.AW(AW), .TW(TW), .BANK_BIT(BB)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in0_vld(in0_vld), .in0_addr(in0_addr), .in0_tag(in0_tag),
    .in1_vld(in1_vld), .in1_addr(in1_addr), .in1_tag(in1_tag),
    .even_vld(even_vld), .even_addr(even_addr), .even_tag(even_tag),
    .odd_vld(odd_vld), .odd_addr(odd_addr), .odd_tag(odd_tag),
    .stall(stall)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [50:0] pack_out(logic s, logic ev, logic [AW-1:0] ea,
      logic [TW-1:0] et, logic ov, logic [AW-1:0] oa, logic [TW-1:0] ot);
    return {s, ev, ea & {AW{ev}}, et & {TW{ev}}, ov, oa & {AW{ov}}, ot & {TW{ov}}};
  endfunction

  // One cycle: drive at negedge, compare combinational outputs, advance model at posedge.
  task automatic step(input logic v0, input logic [AW-1:0] a0, input logic [TW-1:0] t0,
                      input logic v1, input logic [AW-1:0] a1, input logic [TW-1:0] t1,
                      input logic fl, input string req);
    logic ev, ov, es, p0, p1, b0, b1;
    logic [AW-1:0] ea, oa;
    logic [TW-1:0] et, ot;
    logic nhv;
    logic [AW-1:0] nha;
    logic [TW-1:0] nht;
    logic [50:0] expv, actv;
    @(negedge clk);
    in0_vld = v0; in0_addr = a0; in0_tag = t0;
    in1_vld = v1; in1_addr = a1; in1_tag = t1;
    flush = fl;
    #1;
    ev = 0; ov = 0; ea = '0; oa = '0; et = '0; ot = '0; es = 0;
    p0 = 0; p1 = 0; nhv = 0; nha = m_ha; nht = m_ht;
    b0 = a0[BB]; b1 = a1[BB];
    if (!fl) begin
      if (m_hv) begin
        if (m_ha[BB]) begin ov = 1; oa = m_ha; ot = m_ht; end
        else          begin ev = 1; ea = m_ha; et = m_ht; end
      end
      if (v0) begin
        if (b0 ? ov : ev) p0 = 1;
        else if (b0) begin ov = 1; oa = a0; ot = t0; end
        else         begin ev = 1; ea = a0; et = t0; end
      end
      if (v1) begin
        if (b1 ? ov : ev) p1 = 1;
        else if (b1) begin ov = 1; oa = a1; ot = t1; end
        else         begin ev = 1; ea = a1; et = t1; end
      end
      if (p0 && p1) begin
        es = 1;
        ev = m_hv && !m_ha[BB]; ea = m_ha; et = m_ht;
        ov = m_hv &&  m_ha[BB]; oa = m_ha; ot = m_ht;
      end else if (p0) begin nhv = 1; nha = a0; nht = t0; end
      else if (p1)     begin nhv = 1; nha = a1; nht = t1; end
    end
    expv = pack_out(es, ev, ea, et, ov, oa, ot);
    actv = pack_out(stall, even_vld, even_addr, even_tag, odd_vld, odd_addr, odd_tag);
    check(actv === expv, req, "outputs{stall,even,odd}", 64'(actv), 64'(expv));
    m_stall_prev = es;
    @(posedge clk);
    m_hv = nhv; m_ha = nha; m_ht = nht;
  endtask

  localparam logic [AW-1:0] E0 = 16'h0100, E1 = 16'h0230, E2 = 16'h0340;
  localparam logic [AW-1:0] O0 = 16'h0108, O1 = 16'h0238, O2 = 16'h0348;

  initial begin : main
    int unused_seed;
    logic rv0, rv1, rfl;
    logic [AW-1:0] ra0, ra1;
    logic [TW-1:0] rt0, rt1;
    unused_seed = $urandom(32'd20240611);

    repeat (3) @(negedge clk);
    #1;
    // R8: during reset
    check(!even_vld && !odd_vld && !stall, "R8", "reset outputs",
          64'({even_vld, odd_vld, stall}), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    step(0, '0, '0, 0, '0, '0, 0, "R8");

    // R1/R2: different banks, both orders
    step(1, E0, 8'h11, 1, O0, 8'h12, 0, "R2");
    step(1, O1, 8'h13, 1, E1, 8'h14, 0, "R1");
    // R3 then R4/R5: same bank pair, then held plus opposite bank
    step(1, E0, 8'h21, 1, E1, 8'h22, 0, "R3");
    step(1, O0, 8'h23, 0, '0, '0, 0, "R4");
    step(1, O0, 8'h31, 1, O1, 8'h32, 0, "R3");
    step(1, O2, 8'h33, 1, E2, 8'h34, 0, "R5");     // held odd, O2 into slot, E2 issues
    step(0, '0, '0, 0, '0, '0, 0, "R4");
    // R6: held even, both new want even -> stall, then re-present
    step(1, E0, 8'h41, 1, E1, 8'h42, 0, "R3");
    step(1, E2, 8'h43, 1, E0, 8'h44, 0, "R6");
    check(!m_stall_prev == 1'b0, "R6", "stall expected by model", 64'(m_stall_prev), 64'd1);
    step(1, E2, 8'h43, 1, E0, 8'h44, 0, "R6");
    step(0, '0, '0, 0, '0, '0, 0, "R6");
    // R7: flush with a held entry, then idle shows nothing
    step(1, O0, 8'h51, 1, O1, 8'h52, 0, "R3");
    step(1, O2, 8'h53, 1, E0, 8'h54, 1, "R7");
    step(0, '0, '0, 0, '0, '0, 0, "R7");
    // R9: alternating same-bank pairs
    step(1, E0, 8'h61, 1, E1, 8'h62, 0, "R9");
    for (int k = 0; k < 6; k++) begin
      if (k % 2 == 0) step(1, O0, 8'(8'h70 + k), 1, O1, 8'(8'h80 + k), 0, "R9");
      else            step(1, E0, 8'(8'h70 + k), 1, E1, 8'(8'h80 + k), 0, "R9");
      check(!m_stall_prev, "R9", "no stall in alternating stream", 64'(m_stall_prev), 64'd0);
    end
    step(0, '0, '0, 0, '0, '0, 0, "R9");

    // Random stream; inputs kept while stalled
    rv0 = 0; rv1 = 0; ra0 = '0; ra1 = '0; rt0 = '0; rt1 = '0; rfl = 0;
    for (int n = 0; n < 4000; n++) begin
      if (!m_stall_prev) begin
        rv0 = ($urandom % 4) != 0;
        rv1 = ($urandom % 4) != 0;
        ra0 = AW'($urandom);
        ra1 = AW'($urandom);
        rt0 = TW'($urandom);
        rt1 = TW'($urandom);
        rfl = ($urandom % 40) == 0;
      end else begin
        rfl = 0;
      end
      step(rv0, ra0, rt0, rv1, ra1, rt1, rfl, "R5");
    end
    step(0, '0, '0, 0, '0, '0, 0, "R4");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule